// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns a bank of general-purpose inputs into edge interrupts for a parent interrupt controller. Each input first passes through a two-flop synchroniser. An edge detector then watches each synchronised input for one chosen direction: rising or falling, set per pin. When a selected edge is seen, a sticky per-pin status bit is set. Software clears that bit by writing a one to it.

Two summary outputs are registered. The interrupt line is the OR over all pins of status ANDed with the enable bits. The wake line is the OR over all pins of status ANDed with the wake-enable bits. Enable only gates the interrupt line: a status bit is captured whether or not its pin is enabled. Software reaches the four per-pin bit arrays through a simple 32-bit read/write port. Each array takes two words, so up to 64 pins are supported.

Top module: `gpio_edge_irq`

## Requirements
- R1: After a synchronous reset the enable, polarity, status and wake-enable bits are all zero, and `irq_out` and `wake_out` are low.
- R2: Register offsets are: enable 0x00, polarity 0x08, status 0x10, wake-enable 0x18. Address bit 2 picks the word: word 0 holds pins 0..31 and word 1 holds pins 32..63. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: A polarity bit of 0 captures only rising edges on that pin. A polarity bit of 1 captures only falling edges. The other edge direction, and a steady level, never set status.
- R4: `irq_out` is a register holding the OR of (status AND enable). It changes one clock after the status or enable bits change.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: If an edge is detected in the same cycle that a write-one-to-clear hits the same bit, the bit stays set.
- R7: A status bit latches on an edge even when its enable bit is 0. In that case `irq_out` stays low.
- R8: `wake_out` is a register holding the OR of (status AND wake-enable). It does not depend on the enable bits.
- R9: Reads at offsets 0x20 and above return zero, and writes there change nothing. Bits for pins at or above NUM_PINS read as zero and cannot be set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | NUM_PINS | Asynchronous GPIO inputs |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt to the parent controller |
| wake_out | output | 1 | Combined wake request |

## Verification
The bench builds the block with NUM_PINS = 40 and ADDR_W = 8. With 40 pins the second word of each array is present but only partly filled. This lets the bench check that pins 32..39 work and that bits 40..63 read as zero. It also drives a write-one-to-clear in the exact cycle an edge is detected, to show the collision rule of R6.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
  localparam int WORD_BITS = 32;
  localparam int MAX_WORDS = 2;

  // Register select taken from address bits [4:3]
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_POLAR  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_WAKE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int NUM_PINS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] falling_i,
  output logic [NUM_PINS-1:0] edge_o
);
  logic [NUM_PINS-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pins_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic up, down;
    assign up        = sync_q[p] & ~last_q[p];
    assign down      = ~sync_q[p] & last_q[p];
    assign edge_o[p] = falling_i[p] ? down : up;
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_edge_irq_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [NUM_PINS-1:0] edge_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] stat_o,
  output logic [NUM_PINS-1:0] wake_o
);
  localparam int NWORDS = (NUM_PINS + WORD_BITS - 1) / WORD_BITS;
  localparam int PADW   = NWORDS * WORD_BITS;
  localparam int FULLW  = MAX_WORDS * WORD_BITS;
  localparam logic [PADW-1:0] VALID = PADW'({NUM_PINS{1'b1}});

  logic [PADW-1:0] en_q, pol_q, stat_q, wake_q, edge_pad;
  logic            mapped;
  logic            word_idx;
  reg_sel_e        sel;
  logic [1:0]      unused_lsb;

  assign edge_pad   = PADW'(edge_i);
  assign mapped     = (addr_i[ADDR_W-1:5] == '0);
  assign word_idx   = addr_i[2];
  assign sel        = reg_sel_e'(addr_i[4:3]);
  assign unused_lsb = addr_i[1:0];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit;
    logic [WORD_BITS-1:0] clr;
    assign hit = wr_i && mapped && (word_idx == 1'(w));
    assign clr = (hit && sel == SEL_STATUS) ? wdata_i : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q  [w*WORD_BITS +: WORD_BITS] <= '0;
        pol_q [w*WORD_BITS +: WORD_BITS] <= '0;
        stat_q[w*WORD_BITS +: WORD_BITS] <= '0;
        wake_q[w*WORD_BITS +: WORD_BITS] <= '0;
      end else begin
        if (hit && sel == SEL_ENABLE)
          en_q[w*WORD_BITS +: WORD_BITS] <= wdata_i & VALID[w*WORD_BITS +: WORD_BITS];
        if (hit && sel == SEL_POLAR)
          pol_q[w*WORD_BITS +: WORD_BITS] <= wdata_i & VALID[w*WORD_BITS +: WORD_BITS];
        if (hit && sel == SEL_WAKE)
          wake_q[w*WORD_BITS +: WORD_BITS] <= wdata_i & VALID[w*WORD_BITS +: WORD_BITS];
        // a fresh edge wins over a clear of the same bit
        stat_q[w*WORD_BITS +: WORD_BITS] <=
          (stat_q[w*WORD_BITS +: WORD_BITS] & ~clr) | edge_pad[w*WORD_BITS +: WORD_BITS];
      end
    end
  end

  logic [FULLW-1:0] en_f, pol_f, stat_f, wake_f;
  logic [31:0]      rd_word;
  assign en_f   = FULLW'(en_q);
  assign pol_f  = FULLW'(pol_q);
  assign stat_f = FULLW'(stat_q);
  assign wake_f = FULLW'(wake_q);

  always_comb begin
    rd_word = '0;
    if (mapped) begin
      case (sel)
        SEL_ENABLE: rd_word = en_f  [word_idx*WORD_BITS +: WORD_BITS];
        SEL_POLAR:  rd_word = pol_f [word_idx*WORD_BITS +: WORD_BITS];
        SEL_STATUS: rd_word = stat_f[word_idx*WORD_BITS +: WORD_BITS];
        SEL_WAKE:   rd_word = wake_f[word_idx*WORD_BITS +: WORD_BITS];
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_word;
  end

  assign en_o   = en_q  [NUM_PINS-1:0];
  assign pol_o  = pol_q [NUM_PINS-1:0];
  assign stat_o = stat_q[NUM_PINS-1:0];
  assign wake_o = wake_q[NUM_PINS-1:0];

  // R6
  edge_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_pad != '0) |=> ((stat_q & $past(edge_pad)) == $past(edge_pad)));
  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_pad == '0) |=> ((stat_q & ~$past(stat_q)) == '0));
  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !mapped) |=> (rdata_o == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] gpio_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq_out,
  output logic                wake_out
);
  logic [NUM_PINS-1:0] edges, en, pol, stat, wake_en;
  logic                pend_any, wake_any;

  gpio_edge_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .pins_i    (gpio_in),
    .falling_i (pol),
    .edge_o    (edges)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .edge_i  (edges),
    .rdata_o (bus_rdata),
    .en_o    (en),
    .pol_o   (pol),
    .stat_o  (stat),
    .wake_o  (wake_en)
  );

  assign pend_any = |(stat & en);
  assign wake_any = |(stat & wake_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out  <= 1'b0;
      wake_out <= 1'b0;
    end else begin
      irq_out  <= pend_any;
      wake_out <= wake_any;
    end
  end

  // R4
  irq_follows_pending_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(pend_any)));
  // R8
  wake_follows_status_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wake_out == $past(wake_any)));
endmodule

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int NP = 40;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] gpio = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, wake;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_edge_irq #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_edge_irq (
    .clk(clk), .rst(rst), .gpio_in(gpio), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_out(irq), .wake_out(wake)
  );

  // vector: {pin[5:0], polarity, start level, end level, expect set}
  localparam int NV = 9;
  localparam logic [9:0] VEC [NV] = '{
    {6'd0,  1'b0, 1'b0, 1'b1, 1'b1},
    {6'd0,  1'b0, 1'b1, 1'b0, 1'b0},
    {6'd5,  1'b1, 1'b0, 1'b1, 1'b0},
    {6'd5,  1'b1, 1'b1, 1'b0, 1'b1},
    {6'd31, 1'b0, 1'b0, 1'b1, 1'b1},
    {6'd32, 1'b1, 1'b1, 1'b0, 1'b1},
    {6'd39, 1'b0, 1'b0, 1'b1, 1'b1},
    {6'd39, 1'b1, 1'b0, 1'b1, 1'b0},
    {6'd17, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 wake", {31'b0, wake}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      bus_read(8'(a * 4), d);
      check("R1 regs zero", d, 32'h0);
    end

    // R3 table walk
    for (int v = 0; v < NV; v++) begin
      int pin;
      logic [7:0] wofs;
      logic [31:0] bit_m;
      pin   = int'(VEC[v][9:4]);
      wofs  = (pin >= 32) ? 8'h04 : 8'h00;
      bit_m = 32'h1 << (pin % 32);
      bus_write(8'h08, 32'h0);
      bus_write(8'h0C, 32'h0);
      bus_write(8'h08 | wofs, VEC[v][3] ? bit_m : 32'h0);
      @(negedge clk); gpio[pin] = VEC[v][2];
      idle(5);
      bus_write(8'h10, 32'hFFFF_FFFF);
      bus_write(8'h14, 32'hFFFF_FFFF);
      @(negedge clk); gpio[pin] = VEC[v][1];
      idle(5);
      bus_read(8'h10 | wofs, d);
      check("R3 edge capture", d, VEC[v][0] ? bit_m : 32'h0);
    end

    // back to rising everywhere, clean status
    bus_write(8'h08, 32'h0);
    bus_write(8'h0C, 32'h0);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h14, 32'hFFFF_FFFF);

    // R7: status latches with enable off; irq stays low
    @(negedge clk); gpio[4] = 1'b1;
    idle(5);
    bus_read(8'h10, d);
    check("R7 status latched while disabled", d, 32'h10);
    check("R7 irq low while disabled", {31'b0, irq}, 32'h0);

    // R4: enabling a pending pin raises irq one cycle after the enable register
    bus_write(8'h00, 32'h10);
    check("R4 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R4 irq one cycle later", {31'b0, irq}, 32'h1);

    // R8: wake follows status and wake-enable
    bus_write(8'h18, 32'h10);
    idle(1);
    check("R8 wake asserted", {31'b0, wake}, 32'h1);
    bus_write(8'h18, 32'h0);
    idle(1);
    check("R8 wake released", {31'b0, wake}, 32'h0);

    // R5: write 0 leaves status, write 1 clears and irq drops a cycle later
    bus_write(8'h10, 32'h0);
    bus_read(8'h10, d);
    check("R5 write zero keeps", d, 32'h10);
    bus_write(8'h10, 32'h10);
    check("R5 irq still high one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R5 irq low after clear", {31'b0, irq}, 32'h0);
    bus_read(8'h10, d);
    check("R5 status cleared", d, 32'h0);

    // R6: edge on pin 4 in the same cycle as a clear of pins 4 and 6
    @(negedge clk); gpio[4] = 1'b0; gpio[6] = 1'b1;
    idle(5);
    bus_read(8'h10, d);
    check("R6 setup", d, 32'h40);
    @(negedge clk); gpio[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = 8'h10; wdata = 32'h50;
    @(negedge clk); wr = 1'b0;
    bus_read(8'h10, d);
    check("R6 edge survives clear", d, 32'h10);
    idle(1);
    check("R6 irq stays asserted", {31'b0, irq}, 32'h1);

    // R2: offsets and word select
    bus_write(8'h00, 32'hA5A5_A5A5);
    bus_write(8'h08, 32'h5A5A_0000);
    bus_write(8'h0C, 32'h0000_FFFF);
    bus_read(8'h00, d); check("R2 enable word0", d, 32'hA5A5_A5A5);
    bus_read(8'h08, d); check("R2 polarity word0", d, 32'h5A5A_0000);

    // R9: bits above NUM_PINS and unmapped offsets
    bus_read(8'h0C, d); check("R9 upper pins zero", d, 32'h0000_00FF);
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_write(8'h3C, 32'hFFFF_FFFF);
    bus_read(8'h24, d); check("R9 unmapped read", d, 32'h0);
    bus_read(8'h00, d); check("R9 unmapped write ignored", d, 32'hA5A5_A5A5);
    bus_read(8'h1C, d); check("R9 wake word1 untouched", d, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule